// File: doc/BRIEF.md
# SPI Mode-3 Register Access Slave

This block is an SPI slave that runs entirely in the system clock domain and gives an external master access to a small register file. SCLK, MOSI and CS_N are resynchronised and their edges are detected with the system clock. Each transaction carries an 8-bit command followed by 32 data bits. The top bit of the command selects write (1) or read (0), and its low seven bits name the register. A write is handed to the register file as a single-cycle strobe once the frame is complete. A read fetches the register value once the command byte has arrived and then shifts that value out on MISO.

Two registers are handled inside the block. Register 0 is a read-only identity register with a fixed value. Register 9 is a write-only action register, and its low three bits turn into single-cycle pulses. All other registers live outside the block. The write side is a valid-only stream with no back-pressure, because an SPI master cannot be stalled. `wr_valid` is high for exactly one cycle and carries `wr_addr` and `wr_data`, so the consumer must accept it in that cycle. On the read side, `rd_req` is high for one cycle with `rd_addr`, and the block samples `rd_data` in that same cycle.

Top module: `spi_regif`

## Requirements
- R1: MOSI is sampled on each rising SCLK edge while CS_N is low. Bits arrive MSB first: 8 command bits, then 32 data bits. Command bit 7 = 1 means write and 0 means read. Command bits 6..0 are the register address.
- R2: A write frame raises `wr_valid` for exactly one cycle after its 40th rising SCLK edge. `wr_addr` carries command bits 6..0 and `wr_data` carries the 32 data bits, first-received bit in bit 31. No other event raises `wr_valid`.
- R3: A read frame raises `rd_req` for one cycle with `rd_addr` after the 8th rising edge. The value is then driven on MISO MSB first. MISO changes only on falling SCLK edges, and bit 31 appears on the falling edge that follows the 8th rising edge.
- R4: A read of address 0 returns 0xCAFEA51C whatever `rd_data` is. A write to address 0 raises neither `wr_valid` nor any action pulse.
- R5: A write to address 9 raises no `wr_valid`. It pulses `act_pos` if data bit 0 is set, `act_start` if data bit 1 is set, and `act_trig` if data bit 2 is set, each for one cycle and in the same cycle. A read of address 9 returns zero.
- R6: Raising CS_N before the 40th rising edge abandons the frame with no write strobe and no action pulse. The next frame starts again from command bit 7.
- R7: Rising SCLK edges after the 40th within one CS_N-low period are ignored. They cause no second strobe and do not change the written data.
- R8: After reset, and whenever CS_N is high, MISO is low. MISO also stays low during the command byte and throughout a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock, idle high |
| mosi | input | 1 | SPI data from master |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to master |
| wr_valid | output | 1 | One-cycle write strobe, no back-pressure |
| wr_addr | output | 7 | Write register address |
| wr_data | output | 32 | Write data |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 7 | Read register address |
| rd_data | input | 32 | Read value, sampled while rd_req is high |
| act_pos | output | 1 | Single-position request pulse |
| act_start | output | 1 | Acquisition start pulse |
| act_trig | output | 1 | Single-trigger pulse |

## Verification
The assertions rely on a few assumptions about the inputs. CS_N, SCLK and MOSI are assumed to hold each level for at least three system clocks, so that one detected edge finishes its work before the next edge is detected. The master is assumed to change MOSI only alongside falling SCLK. The bench drives every SCLK half-period as six system clocks. It lowers CS_N one half-period before the first clock, changes MOSI only together with the falling edge, and samples MISO just before each rising edge. Aborted frames, over-length frames and frames to address 0 and address 9 all follow the same timing.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int CMD_W     = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = CMD_W - 1;
  localparam int FRAME_LEN = CMD_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int ACT_N     = 3;
  localparam logic [ADDR_W-1:0] ID_ADDR  = 7'd0;
  localparam logic [ADDR_W-1:0] ACT_ADDR = 7'd9;
  localparam logic [DATA_W-1:0] ID_VALUE = 32'hCAFEA51C;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_word_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      mosi_s,
  input  logic      csn_s,
  input  reg_word_t rd_value,
  output logic      rd_pend,
  output reg_addr_t cmd_addr,
  output logic      frm_wr,
  output reg_word_t frm_data,
  output logic      miso
);
  logic             sclk_d;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  reg_word_t        sh, tx;
  logic [CMD_W-1:0] cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d & ~csn_s;
  assign fall = ~sclk_s & sclk_d & ~csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      cmd     <= '0;
      rd_pend <= 1'b0;
      frm_wr  <= 1'b0;
      miso    <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      frm_wr  <= 1'b0;
      if (csn_s) begin
        cnt  <= '0;
        miso <= 1'b0;
      end else begin
        if (rise && cnt < CNT_W'(FRAME_LEN)) begin
          sh  <= {sh[DATA_W-2:0], mosi_s};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CMD_W - 1)) begin
            cmd     <= {sh[CMD_W-2:0], mosi_s};
            rd_pend <= ~sh[CMD_W-2];
          end
          if (cnt == CNT_W'(FRAME_LEN - 1) && cmd[CMD_W-1])
            frm_wr <= 1'b1;
        end
        if (rd_pend) tx <= rd_value;
        if (fall && !cmd[CMD_W-1] && cnt >= CNT_W'(CMD_W) && cnt < CNT_W'(FRAME_LEN)) begin
          miso <= tx[DATA_W-1];
          tx   <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign cmd_addr = cmd[ADDR_W-1:0];
  assign frm_data = sh;

  // R6
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt == '0));
  // R7
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_LEN));
  // R3
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> !rd_pend);
  // R3
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !csn_s) |=> $stable(miso));
  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso);
endmodule

// File: rtl/spi_decode.sv
module spi_decode
  import spi_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_wr,
  input  reg_addr_t        addr,
  input  reg_word_t        frm_data,
  input  reg_word_t        ext_rd_data,
  output reg_word_t        rd_value,
  output logic             wr_valid,
  output reg_addr_t        wr_addr,
  output reg_word_t        wr_data,
  output logic [ACT_N-1:0] act
);
  logic is_id, is_act;

  assign is_id  = (addr == ID_ADDR);
  assign is_act = (addr == ACT_ADDR);

  always_comb begin
    if (is_id)       rd_value = ID_VALUE;
    else if (is_act) rd_value = '0;
    else             rd_value = ext_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= frm_wr && !is_id && !is_act;
      if (frm_wr) begin
        wr_addr <= addr;
        wr_data <= frm_data;
      end
    end
  end

  for (genvar b = 0; b < ACT_N; b++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act[b] <= 1'b0;
      else        act[b] <= frm_wr && is_act && frm_data[b];
    end
  end

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4
  no_ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr != ID_ADDR && wr_addr != ACT_ADDR));
  // R5
  act_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |=> (act == '0));
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        mosi,
  input  logic        cs_n,
  output logic        miso,
  output logic        wr_valid,
  output logic [6:0]  wr_addr,
  output logic [31:0] wr_data,
  output logic        rd_req,
  output logic [6:0]  rd_addr,
  input  logic [31:0] rd_data,
  output logic        act_pos,
  output logic        act_start,
  output logic        act_trig
);
  logic [2:0]       pins_s;
  reg_addr_t        cmd_addr;
  logic             frm_wr;
  reg_word_t        frm_data, rd_value;
  logic [ACT_N-1:0] act;

  spi_sync #(.W(3), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, mosi, sclk}), .q(pins_s));

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .csn_s(pins_s[2]),
    .rd_value(rd_value), .rd_pend(rd_req), .cmd_addr(cmd_addr),
    .frm_wr(frm_wr), .frm_data(frm_data), .miso(miso));

  spi_decode u_dec (
    .clk(clk), .rst_n(rst_n), .frm_wr(frm_wr), .addr(cmd_addr),
    .frm_data(frm_data), .ext_rd_data(rd_data), .rd_value(rd_value),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .act(act));

  assign rd_addr   = cmd_addr;
  assign act_pos   = act[0];
  assign act_start = act[1];
  assign act_trig  = act[2];
endmodule

// File: tb/spi_regif_test.sv
module spi_regif_test;
  localparam int H = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, mosi = 1'b0, cs_n = 1'b1;
  logic miso, wr_valid, rd_req, act_pos, act_start, act_trig;
  logic [6:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  int total = 0, bad = 0;
  logic [6:0]  q_waddr[$];
  logic [31:0] q_wdata[$];
  logic [2:0]  q_act[$];
  logic [6:0]  q_raddr[$];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ext_val(input logic [6:0] a);
    return 32'h1F2E3D4C ^ {4{1'b0, a}};
  endfunction
  assign rd_data = ext_val(rd_addr);

  spi_regif uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference monitor, every clock
  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      if (q_waddr.size() == 0) chk("R2 unexpected wr_valid", {25'd0, wr_addr}, 32'hFFFFFFFF);
      else begin
        chk("R2 wr_addr", {25'd0, wr_addr}, {25'd0, q_waddr.pop_front()});
        chk("R1 wr_data", wr_data, q_wdata.pop_front());
      end
    end
    if ({act_trig, act_start, act_pos} != 3'b000) begin
      if (q_act.size() == 0) chk("R5 unexpected action", {29'd0, act_trig, act_start, act_pos}, 32'd0);
      else chk("R5 action bits", {29'd0, act_trig, act_start, act_pos}, {29'd0, q_act.pop_front()});
    end
    if (rd_req) begin
      if (q_raddr.size() == 0) chk("R3 unexpected rd_req", {25'd0, rd_addr}, 32'hFFFFFFFF);
      else chk("R3 rd_addr", {25'd0, rd_addr}, {25'd0, q_raddr.pop_front()});
    end
  end

  // rexp: value expected on MISO during data phase (0 for write frames)
  task automatic frame(input logic [7:0] cmd, input logic [31:0] data, input int nbits,
                       input logic [31:0] rexp, input string tag);
    logic [39:0] f = {cmd, data};
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = (i < 40) ? f[39-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i < 40) chk((i < 8) ? "R8 miso in command" : tag, {31'd0, miso},
                      (i < 8) ? 32'd0 : {31'd0, rexp[39-i]});
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
    chk("R8 miso idle", {31'd0, miso}, 32'd0);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input int nbits, input bit expect_wr);
    if (expect_wr) begin q_waddr.push_back(a); q_wdata.push_back(d); end
    frame({1'b1, a}, d, nbits, 32'd0, "R8 miso in write");
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input int nbits, input string tag);
    q_raddr.push_back(a);
    frame({1'b0, a}, 32'd0, nbits, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8 reset state
    chk("R8 reset miso", {31'd0, miso}, 32'd0);
    chk("R2 reset wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R5 reset actions", {29'd0, act_trig, act_start, act_pos}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 R2 plain writes
    wr(7'd3, 32'h00124F7F, 40, 1'b1);
    wr(7'h55, 32'hDEADBEEF, 40, 1'b1);
    // R3 read of an external register
    rd(7'h2A, ext_val(7'h2A), 40, "R3 miso read data");
    rd(7'h7F, ext_val(7'h7F), 40, "R3 miso read data");
    // R4 identity register
    rd(7'd0, 32'hCAFEA51C, 40, "R4 id value");
    wr(7'd0, 32'h12345678, 40, 1'b0);
    // R5 action register
    q_act.push_back(3'b101);
    wr(7'd9, 32'h00000005, 40, 1'b0);
    q_act.push_back(3'b010);
    wr(7'd9, 32'hFFFFFFFA, 40, 1'b0);
    wr(7'd9, 32'h00000000, 40, 1'b0);
    rd(7'd9, 32'd0, 40, "R5 action reads zero");
    // R6 aborted frames then recovery
    wr(7'd4, 32'hA5A5A5A5, 20, 1'b0);
    rd(7'd5, ext_val(7'd5), 12, "R6 partial read");
    wr(7'd4, 32'h0BADF00D, 40, 1'b1);
    q_act.push_back(3'b100);
    wr(7'd9, 32'h00000004, 39, 1'b0);
    q_act.pop_back();
    wr(7'd6, 32'h80000001, 40, 1'b1);
    // R7 extra clocks after the 40th bit
    wr(7'd11, 32'h0000FF0A, 44, 1'b1);
    rd(7'd10, ext_val(7'd10), 45, "R7 miso read long frame");
    repeat (20) @(negedge clk);
    chk("R2 all writes seen", q_waddr.size(), 32'd0);
    chk("R5 all actions seen", q_act.size(), 32'd0);
    chk("R3 all reads seen", q_raddr.size(), 32'd0);
    chk("R6 no action from aborted frame", {29'd0, act_trig, act_start, act_pos}, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule